// File: doc/BRIEF.md
# Synchronous Block-Read Bus Sequencer

This block is the memory-side sequencer of a synchronous bus whose 64-bit lines carry first an address and then data. A requester pulses a start strobe together with a word address and a block size in words. The sequencer spends one bus cycle on the address. It then waits out the access time of its internal memory model. Next it returns the block in groups of four 32-bit words, each group as two 64-bit beats, and holds the bus quiet for two cycles after every group.

The memory only reads four words at a time. Sizes are therefore rounded up to whole groups, and sizes outside the legal set raise an error flag. Only the first group of a block pays the full access latency. The read of each later group is issued as the previous group starts sending, so it completes inside that group's send and quiet cycles. Each extra group then costs four cycles. A 4-word block takes 45 cycles and a 16-word block takes 57.

The state machine has five states. `ST_IDLE` waits for a start. `ST_ADDR` is the address cycle and issues the first read. `ST_WAIT` waits for the first group. `ST_SEND` drives the two beats. `ST_GAP` holds the quiet cycles. Its transitions are:
- accept (`ST_IDLE`→`ST_ADDR`)
- issue (`ST_ADDR`→`ST_WAIT`)
- first-data (`ST_WAIT`→`ST_SEND`)
- beats-done (`ST_SEND`→`ST_GAP`)
- next-group (`ST_GAP`→`ST_SEND`, when groups remain and data is ready)
- finish (`ST_GAP`→`ST_IDLE`, on the last quiet cycle of the last group)

Top module: `blk_xfer_ctrl`

## Requirements
- R1: While and after reset, until a start is accepted: `busy_o`, `data_valid_o`, `done_o` and `size_err_o` are 0 and `bus_data_o` is all zeros.
- R2: A `start_i` high at a rising edge while idle is accepted. The cycle after that edge is the address cycle: `busy_o` is 1, `data_valid_o` is 0, and `bus_data_o` carries the start address zero-extended to 64 bits.
- R3: The first data beat appears exactly FIRST_LAT (40) cycles after the address cycle, in cycle 42 when the address cycle is cycle 1. In the cycles between, `bus_data_o` is zero and `data_valid_o` is 0.
- R4: Each group at word address g is sent as two consecutive beats with `data_valid_o` high: beat 0 = {word(g+1), word(g)} and beat 1 = {word(g+3), word(g+2)}. Here word(a) = (a × 0x9E3779B1 mod 2^32) XOR 0xC3A50F96. Group k of a block starts at word address start + 4k, and addresses wrap modulo 2^16.
- R5: After each group's second beat, two cycles follow with `data_valid_o` 0 and `bus_data_o` zero.
- R6: Each later group's first beat comes exactly 4 cycles after the previous group's first beat, so a block of G groups occupies 41 + 4G cycles (45 for one group, 57 for four).
- R7: The group count is the block size divided by 4 and rounded up, clamped to the range 1 to 4; a size of 0 gives one group.
- R8: `size_err_o` goes high in the address cycle when the requested size is not 4, 8, 12 or 16, low when it is, and holds that value until the next accepted start.
- R9: `done_o` is a single-cycle pulse on the last quiet cycle of the last group, and `busy_o` falls in the following cycle.
- R10: A start strobe seen while busy, including the quiet cycles and the `done_o` cycle, is ignored: the running block finishes unchanged and the controller is idle afterwards.
- R11: A start in the cycle right after `done_o` is accepted, so blocks can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for a block read |
| addr_i | input | 16 | Start word address, sampled on accept |
| size_i | input | 5 | Requested block size in words, sampled on accept |
| bus_data_o | output | 64 | Multiplexed bus: address in the address cycle, data beats when valid |
| data_valid_o | output | 1 | High on each data beat |
| done_o | output | 1 | Pulse on the last quiet cycle of a block |
| busy_o | output | 1 | High from the address cycle through the last quiet cycle |
| size_err_o | output | 1 | Requested size was rounded or clamped |

## Verification
Directed blocks of one and four groups pin down the 45- and 57-cycle totals and separate the full first-group latency from the overlapped four-cycle cadence of later groups. Sizes 0, 3, 5, 17 and 31 exercise rounding and clamping against the error flag. A start address just below the 16-bit limit shows whether group addresses wrap. Random sizes and addresses, some with junk start strobes fired during the busy and quiet cycles, tell an ignored strobe from a restart. Every block is launched in the cycle right after the previous `done_o`, which checks back-to-back acceptance.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

    localparam int GRP_WORDS = 4;
    localparam int GRP_SHIFT = 2;
    localparam int BEATS     = 2;
    localparam int GRP_BITS  = 32 * GRP_WORDS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_SEND,
        ST_GAP
    } seq_state_t;

    // Content of the internal memory model at a given word address.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hC3A5_0F96;
    endfunction

endpackage

// File: rtl/blk_xfer_size.sv
module blk_xfer_size
    import blk_xfer_pkg::*;
#(
    parameter int SZW      = 5,
    parameter int MAX_GRPS = 4,
    parameter int GW       = 3
) (
    input  logic [SZW-1:0] size_i,
    output logic [GW-1:0]  ngrp_o,
    output logic           err_o
);
    localparam int UW = SZW + 1;

    logic [UW-1:0] up;
    logic [UW-1:0] raw;

    always_comb begin
        up    = {1'b0, size_i} + UW'(GRP_WORDS - 1);
        raw   = up >> GRP_SHIFT;
        err_o = (size_i[GRP_SHIFT-1:0] != '0) || (raw == '0) || (raw > UW'(MAX_GRPS));
        if (raw == '0) begin
            ngrp_o = GW'(1);
        end else if (raw > UW'(MAX_GRPS)) begin
            ngrp_o = GW'(MAX_GRPS);
        end else begin
            ngrp_o = GW'(raw);
        end
    end
endmodule

// File: rtl/blk_xfer_mem.sv
module blk_xfer_mem
    import blk_xfer_pkg::*;
#(
    parameter int AW        = 16,
    parameter int FIRST_LAT = 40,
    parameter int NEXT_LAT  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic                first_i,
    input  logic                ack_i,
    input  logic [AW-1:0]       addr_i,
    output logic                rdy_o,
    output logic [GRP_BITS-1:0] data_o
);
    localparam int LMAX = (FIRST_LAT > NEXT_LAT) ? FIRST_LAT : NEXT_LAT;
    localparam int CW   = $clog2(LMAX + 1);

    logic [GRP_BITS-1:0] word_nxt;
    logic [GRP_BITS-1:0] data_q;
    logic [CW-1:0]       cnt_q;
    logic                pend_q;

    for (genvar i = 0; i < GRP_WORDS; i++) begin : g_word
        logic [AW-1:0] wa;
        assign wa = addr_i + AW'(i);
        assign word_nxt[32*i +: 32] = mem_word(32'(wa));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            data_q <= '0;
        end else if (req_i) begin
            pend_q <= 1'b1;
            cnt_q  <= first_i ? CW'(FIRST_LAT - 1) : CW'(NEXT_LAT - 1);
            data_q <= word_nxt;
        end else begin
            if (ack_i) begin
                pend_q <= 1'b0;
            end
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign rdy_o  = pend_q && (cnt_q == '0);
    assign data_o = data_q;
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int AW       = 16,
    parameter int GW       = 3,
    parameter int IDLE_CYC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [GW-1:0]       ngrp_i,
    input  logic                size_err_i,
    input  logic                mem_rdy_i,
    input  logic [GRP_BITS-1:0] mem_data_i,
    output logic                mem_req_o,
    output logic                mem_first_o,
    output logic                mem_ack_o,
    output logic [AW-1:0]       mem_addr_o,
    output logic [63:0]         bus_data_o,
    output logic                data_valid_o,
    output logic                done_o,
    output logic                busy_o,
    output logic                size_err_o
);
    localparam int CW = $clog2(IDLE_CYC + BEATS);

    seq_state_t          state, nxt;
    logic [CW-1:0]       cnt_q, cnt_nxt;
    logic [GW-1:0]       grp_q, grp_nxt;
    logic [AW-1:0]       rd_q, rd_nxt;
    logic [GRP_BITS-1:0] grp_buf_q;
    logic                err_q;
    logic                accept, take, load_buf;

    // State register and datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt_q     <= '0;
            grp_q     <= '0;
            rd_q      <= '0;
            grp_buf_q <= '0;
            err_q     <= 1'b0;
        end else begin
            state <= nxt;
            cnt_q <= cnt_nxt;
            grp_q <= grp_nxt;
            rd_q  <= rd_nxt;
            if (load_buf) begin
                grp_buf_q <= mem_data_i;
            end
            if (accept) begin
                err_q <= size_err_i;
            end
        end
    end

    // Next state and memory control.
    always_comb begin
        nxt         = state;
        cnt_nxt     = cnt_q;
        grp_nxt     = grp_q;
        rd_nxt      = rd_q;
        accept      = 1'b0;
        take        = 1'b0;
        load_buf    = 1'b0;
        mem_req_o   = 1'b0;
        mem_first_o = 1'b0;
        mem_ack_o   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_i) begin
                    accept  = 1'b1;
                    nxt     = ST_ADDR;
                    rd_nxt  = addr_i;
                    grp_nxt = ngrp_i;
                    cnt_nxt = '0;
                end
            end
            ST_ADDR: begin
                mem_req_o   = 1'b1;
                mem_first_o = 1'b1;
                rd_nxt      = rd_q + AW'(GRP_WORDS);
                nxt         = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rdy_i) begin
                    take = 1'b1;
                end
            end
            ST_SEND: begin
                if (cnt_q == CW'(BEATS - 1)) begin
                    nxt     = ST_GAP;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt_q + CW'(1);
                end
            end
            ST_GAP: begin
                if (cnt_q == CW'(IDLE_CYC - 1)) begin
                    if (grp_q == '0) begin
                        nxt = ST_IDLE;
                    end else if (mem_rdy_i) begin
                        take = 1'b1;
                    end
                end else begin
                    cnt_nxt = cnt_q + CW'(1);
                end
            end
            default: nxt = ST_IDLE;
        endcase
        if (take) begin
            nxt       = ST_SEND;
            cnt_nxt   = '0;
            mem_ack_o = 1'b1;
            load_buf  = 1'b1;
            grp_nxt   = grp_q - GW'(1);
            if (grp_q > GW'(1)) begin
                mem_req_o = 1'b1;
                rd_nxt    = rd_q + AW'(GRP_WORDS);
            end
        end
    end

    // Outputs.
    always_comb begin
        busy_o       = (state != ST_IDLE);
        data_valid_o = (state == ST_SEND);
        done_o       = (state == ST_GAP) && (cnt_q == CW'(IDLE_CYC - 1)) && (grp_q == '0);
        size_err_o   = err_q;
        mem_addr_o   = rd_q;
        case (state)
            ST_ADDR: bus_data_o = 64'(rd_q);
            ST_SEND: bus_data_o = (cnt_q == '0) ? grp_buf_q[63:0] : grp_buf_q[127:64];
            default: bus_data_o = '0;
        endcase
    end
endmodule

// File: rtl/blk_xfer_ctrl.sv
module blk_xfer_ctrl
    import blk_xfer_pkg::*;
#(
    parameter int AW        = 16,
    parameter int SZW       = 5,
    parameter int MAX_WORDS = 16,
    parameter int FIRST_LAT = 40,
    parameter int NEXT_LAT  = 4,
    parameter int IDLE_CYC  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [SZW-1:0] size_i,
    output logic [63:0]    bus_data_o,
    output logic           data_valid_o,
    output logic           done_o,
    output logic           busy_o,
    output logic           size_err_o
);
    localparam int MAX_GRPS = MAX_WORDS / GRP_WORDS;
    localparam int GW       = $clog2(MAX_GRPS + 1);

    logic [GW-1:0]       ngrp;
    logic                size_err;
    logic                mem_req, mem_first, mem_ack, mem_rdy;
    logic [AW-1:0]       mem_addr;
    logic [GRP_BITS-1:0] mem_data;

    blk_xfer_size #(.SZW(SZW), .MAX_GRPS(MAX_GRPS), .GW(GW)) u_size (
        .size_i (size_i),
        .ngrp_o (ngrp),
        .err_o  (size_err)
    );

    blk_xfer_mem #(.AW(AW), .FIRST_LAT(FIRST_LAT), .NEXT_LAT(NEXT_LAT)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (mem_req),
        .first_i (mem_first),
        .ack_i   (mem_ack),
        .addr_i  (mem_addr),
        .rdy_o   (mem_rdy),
        .data_o  (mem_data)
    );

    blk_xfer_seq #(.AW(AW), .GW(GW), .IDLE_CYC(IDLE_CYC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .addr_i       (addr_i),
        .ngrp_i       (ngrp),
        .size_err_i   (size_err),
        .mem_rdy_i    (mem_rdy),
        .mem_data_i   (mem_data),
        .mem_req_o    (mem_req),
        .mem_first_o  (mem_first),
        .mem_ack_o    (mem_ack),
        .mem_addr_o   (mem_addr),
        .bus_data_o   (bus_data_o),
        .data_valid_o (data_valid_o),
        .done_o       (done_o),
        .busy_o       (busy_o),
        .size_err_o   (size_err_o)
    );
endmodule

// File: rtl/blk_xfer_chk.sv
module blk_xfer_chk #(
    parameter int FIRST_LAT = 40
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [63:0] bus_data_o,
    input logic        data_valid_o,
    input logic        done_o,
    input logic        busy_o
);
    logic [15:0] cyc_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            seen_q <= 1'b0;
        end else if (start_i && !busy_o) begin
            cyc_q  <= 16'd1;
            seen_q <= 1'b0;
        end else if (busy_o) begin
            cyc_q  <= cyc_q + 16'd1;
            seen_q <= seen_q | data_valid_o;
        end
    end

    a_r3_first_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(data_valid_o) && !seen_q) |-> (cyc_q == 16'(FIRST_LAT + 2)));

    a_r4_beat_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid_o) |=> data_valid_o);

    a_r4_two_beats_max: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid_o && $past(data_valid_o)) |=> !data_valid_o);

    a_r5_quiet_after_group: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_valid_o) |=> (!data_valid_o && bus_data_o == 64'd0));

    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && !done_o));

    a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    a_r5_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |-> (busy_o && !done_o));
endmodule

bind blk_xfer_ctrl blk_xfer_chk #(.FIRST_LAT(FIRST_LAT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .bus_data_o   (bus_data_o),
    .data_valid_o (data_valid_o),
    .done_o       (done_o),
    .busy_o       (busy_o)
);

// File: tb/blk_xfer_ctrl_tb_top.sv
module blk_xfer_ctrl_tb_top;
    localparam int FIRST = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [4:0]  size_i = '0;
    logic [63:0] bus_data_o;
    logic        data_valid_o, done_o, busy_o, size_err_o;

    int  vecs  = 0;
    int  fails = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    blk_xfer_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .addr_i       (addr_i),
        .size_i       (size_i),
        .bus_data_o   (bus_data_o),
        .data_valid_o (data_valid_o),
        .done_o       (done_o),
        .busy_o       (busy_o),
        .size_err_o   (size_err_o)
    );

    function automatic logic [31:0] exp_word(input logic [15:0] a);
        return (32'(a) * 32'h9E37_79B1) ^ 32'hC3A5_0F96;
    endfunction

    function automatic int exp_groups(input int sz);
        int g = (sz + 3) / 4;
        if (g == 0) g = 1;
        if (g > 4) g = 4;
        return g;
    endfunction

    function automatic bit exp_err(input int sz);
        return (sz % 4 != 0) || (sz < 4) || (sz > 16);
    endfunction

    task automatic cmp64(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Caller is at a falling edge with the controller idle (or finishing).
    task automatic xfer(input logic [15:0] a, input int sz, input bit junk, input bit btb);
        int  g     = exp_groups(sz);
        int  total = 41 + 4 * g;
        bit  err   = exp_err(sz);
        int  beats = 0;
        start_i = 1'b1;
        addr_i  = a;
        size_i  = 5'(sz);
        for (int n = 1; n <= total + 1; n++) begin
            logic [63:0] eb;
            logic        ev, ed, ebz;
            string       tag;
            @(negedge clk);
            eb = '0; ev = 1'b0; ed = 1'b0; ebz = (n <= total);
            if (n == 1) begin
                eb  = 64'(a);
                tag = btb ? "R11" : "R2";
            end else if (n <= FIRST + 1) begin
                tag = "R3";
            end else if (n <= total) begin
                int off = n - (FIRST + 2);
                int k   = off / 4;
                int ph  = off % 4;
                logic [15:0] ga = a + 16'(4 * k);
                if (ph < 2) begin
                    ev  = 1'b1;
                    eb  = (ph == 0) ? {exp_word(ga + 16'd1), exp_word(ga)}
                                    : {exp_word(ga + 16'd3), exp_word(ga + 16'd2)};
                    tag = (k == 0) ? "R4" : "R6";
                end else begin
                    tag = "R5";
                    if (n == total) begin
                        ed  = 1'b1;
                        tag = "R9";
                    end
                end
            end else begin
                tag = "R10";
            end
            vecs++;
            if (data_valid_o) beats++;
            cmp64(tag, "bus_data_o", bus_data_o, eb);
            cmp64(tag, "data_valid_o", 64'(data_valid_o), 64'(ev));
            cmp64(tag, "done_o", 64'(done_o), 64'(ed));
            cmp64(tag, "busy_o", 64'(busy_o), 64'(ebz));
            cmp64("R8", "size_err_o", 64'(size_err_o), 64'(err));
            if (junk && n <= total) begin
                start_i = 1'($urandom_range(0, 1));
                addr_i  = 16'($urandom);
                size_i  = 5'($urandom);
            end else begin
                start_i = 1'b0;
            end
        end
        vecs++;
        cmp64("R7", "beat count", 64'(beats), 64'(2 * g));
    endtask

    task automatic idle_check(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            vecs++;
            cmp64("R10", "busy_o idle", 64'(busy_o), 64'd0);
            cmp64("R10", "data_valid_o idle", 64'(data_valid_o), 64'd0);
        end
    endtask

    initial begin
        int unsigned s;
        s = $urandom(32'd7331);
        repeat (3) @(negedge clk);
        vecs++;
        cmp64("R1", "busy_o in reset", 64'(busy_o), 64'd0);
        cmp64("R1", "bus_data_o in reset", bus_data_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        vecs++;
        cmp64("R1", "busy_o", 64'(busy_o), 64'd0);
        cmp64("R1", "data_valid_o", 64'(data_valid_o), 64'd0);
        cmp64("R1", "done_o", 64'(done_o), 64'd0);
        cmp64("R1", "size_err_o", 64'(size_err_o), 64'd0);
        cmp64("R1", "bus_data_o", bus_data_o, 64'd0);

        xfer(16'h0000, 4, 1'b0, 1'b0);
        xfer(16'h1234, 16, 1'b1, 1'b1);
        xfer(16'hFFFE, 8, 1'b0, 1'b1);
        xfer(16'h0040, 0, 1'b1, 1'b1);
        xfer(16'h0100, 3, 1'b0, 1'b1);
        xfer(16'h0200, 5, 1'b1, 1'b1);
        xfer(16'hFFF9, 17, 1'b0, 1'b1);
        xfer(16'h7777, 31, 1'b1, 1'b1);
        xfer(16'hABCD, 12, 1'b0, 1'b1);
        idle_check(3);
        for (int t = 0; t < 20; t++) begin
            xfer(16'($urandom), int'($urandom_range(0, 31)), 1'($urandom_range(0, 1)), 1'b1);
            if ($urandom_range(0, 3) == 0) idle_check(int'($urandom_range(1, 4)));
        end
        idle_check(2);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual still running, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end
endmodule